// File: doc/BRIEF.md
# Trace channel console decoder

The block sits behind a 64 KB address window made of byte-write-only trace channels, each channel owning a 64-byte slice. It turns writes into the window into a character stream for a console. The channel number is taken from the write address. One control channel acts as a flush and produces a carriage return. Every other channel carries console text, with three exceptions:
- two open-channel marker values are swallowed;
- a zero byte becomes a line feed;
- all remaining bytes pass through unchanged.

The output is a single held byte with a valid/ready handshake. While that byte waits to be taken, the bus side is stalled. The block accepts reads and writes that are not byte-wide, flags them as errors, and emits nothing for them.

Top module: `trace_console_dec`

## Requirements
- R1: The channel number is address bits [13:6]. Bits [5:0] (the position inside a slice) and bits [15:14] do not affect decoding, so channel slices alias every 16 KB.
- R2: An accepted byte write to channel 253 emits exactly one character 0x0D, whatever the data value.
- R3: An accepted byte write to any channel other than 253 with data 0xC0 or 0xC3 emits nothing.
- R4: An accepted byte write to any channel other than 253 with data 0x00 emits 0x0A.
- R5: An accepted byte write to any channel other than 253 with any other data emits that byte unchanged. Only bits [7:0] of `bus_wdata_i` are used.
- R6: `bus_size_i` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. An accepted write with a size other than 0 emits nothing and raises `bus_err_o` for exactly the cycle after acceptance.
- R7: An accepted read (`bus_write_i` = 0) emits nothing and raises `bus_err_o` for the cycle after acceptance. `bus_rdata_o` is always zero.
- R8: An access is accepted on a clock edge where `bus_valid_i` and `bus_ready_o` are both high. `bus_ready_o` is low exactly while `char_valid_o` is high. An emitted character appears on `char_o` with `char_valid_o` high in the cycle after acceptance. It is held stable until the edge where `char_ready_i` is high.
- R9: While `rst_ni` is low, `char_valid_o` and `bus_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_addr_i | input | 16 | Offset within the channel window |
| bus_wdata_i | input | 32 | Write data; low byte is the character |
| bus_ready_o | output | 1 | Access accepted on this edge when high |
| bus_rdata_o | output | 32 | Read data, always zero |
| bus_err_o | output | 1 | Error pulse for a read or non-byte write |
| char_o | output | 8 | Output character |
| char_valid_o | output | 1 | Output character valid |
| char_ready_i | input | 1 | Console takes the character |

## Verification
The bench writes the marker values and their neighbours 0xC1 and 0xFF. A decoder that compares too few bits would swallow the neighbours or pass the markers. Control-channel writes carry non-zero data at odd offsets inside the slice and through the aliased upper address bits. A wrong slice field would print the data instead of a carriage return. Word writes carry junk in the upper data bits, halfword and word writes are mixed with reads, and a slow console holds back consecutive characters. A design that lost the stall would drop or overwrite a character, and one that decoded size loosely would print error data.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [7:0] CHR_CR   = 8'h0D;
  localparam logic [7:0] CHR_LF   = 8'h0A;
  localparam logic [7:0] CHR_NUL  = 8'h00;
  localparam logic [7:0] MARK_OPA = 8'hC0;
  localparam logic [7:0] MARK_OPB = 8'hC3;
endpackage

// File: rtl/tcd_classify.sv
module tcd_classify
  import tcd_pkg::*;
#(
  parameter int          CH_W    = 8,
  parameter int unsigned CTRL_CH = 253
) (
  input  logic [CH_W-1:0] chan_i,
  input  logic [7:0]      byte_i,
  output logic            emit_o,
  output logic [7:0]      code_o
);
  localparam logic [CH_W-1:0] CtrlCh = CH_W'(CTRL_CH);

  always_comb begin
    emit_o = 1'b1;
    code_o = byte_i;
    if (chan_i == CtrlCh) begin
      code_o = CHR_CR;
    end else if (byte_i == MARK_OPA || byte_i == MARK_OPB) begin
      emit_o = 1'b0;
    end else if (byte_i == CHR_NUL) begin
      code_o = CHR_LF;
    end
  end
endmodule

// File: rtl/tcd_char_hold.sv
module tcd_char_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o);
endmodule

// File: rtl/trace_console_dec.sv
module trace_console_dec
  import tcd_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 32,
  parameter int          SLICE_W = 6,
  parameter int          CH_W    = 8,
  parameter int unsigned CTRL_CH = 253
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ready_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  output logic [7:0]        char_o,
  output logic              char_valid_o,
  input  logic              char_ready_i
);
  localparam logic [CH_W-1:0] CtrlCh = CH_W'(CTRL_CH);

  logic            acc;
  logic            good_wr;
  logic [CH_W-1:0] chan;
  logic [7:0]      wbyte;
  logic            emit;
  logic [7:0]      code;
  logic            unused_bits;

  assign chan        = bus_addr_i[SLICE_W +: CH_W];
  assign wbyte       = bus_wdata_i[7:0];
  assign unused_bits = ^{bus_addr_i, bus_wdata_i};

  assign bus_ready_o = !char_valid_o;
  assign bus_rdata_o = '0;
  assign acc         = bus_valid_i && bus_ready_o;
  assign good_wr     = bus_write_i && (acc_size_e'(bus_size_i) == SZ_BYTE);

  tcd_classify #(.CH_W(CH_W), .CTRL_CH(CTRL_CH)) u_classify (
    .chan_i (chan),
    .byte_i (wbyte),
    .emit_o (emit),
    .code_o (code)
  );

  tcd_char_hold #(.W(8)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (acc && good_wr && emit),
    .data_i  (code),
    .ready_i (char_ready_i),
    .valid_o (char_valid_o),
    .data_o  (char_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_err_o <= 1'b0;
    else         bus_err_o <= acc && !good_wr;
  end

  assert_err_after_bad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && bus_write_i && bus_size_i != 2'd0 |=> bus_err_o && !char_valid_o);

  assert_err_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !bus_write_i |=> bus_err_o && !char_valid_o);

  assert_flush_cr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && good_wr && chan == CtrlCh |=> char_valid_o && char_o == CHR_CR);

  assert_marker_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && good_wr && chan != CtrlCh && (wbyte == MARK_OPA || wbyte == MARK_OPB)
    |=> !char_valid_o && !bus_err_o);

  assert_nul_lf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && good_wr && chan != CtrlCh && wbyte == CHR_NUL |=> char_valid_o && char_o == CHR_LF);
endmodule

// File: tb/trace_console_dec_bench.sv
`timescale 1ns/1ps
module trace_console_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        char_ready = 1'b1;
  logic        bus_ready_o, bus_err_o, char_valid_o;
  logic [31:0] bus_rdata_o;
  logic [7:0]  char_o;

  always #5 clk = ~clk;

  trace_console_dec u_trace_console_dec (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_size_i(bus_size), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_ready_o(bus_ready_o), .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o),
    .char_o(char_o), .char_valid_o(char_valid_o), .char_ready_i(char_ready)
  );

  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 0, sink_slow = 0, exp_hold = 0, exp_err = 0;
  byte  exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, evaluated at each active edge
  always @(posedge clk) begin
    if (rst_n) begin
      int ch, b;
      if (exp_hold && char_ready) begin
        void'(exp_q.pop_front());
        exp_hold = 0;
      end
      exp_err = 0;
      if (bus_valid && !exp_hold_before()) begin
        if (!bus_write || bus_size != 2'd0) exp_err = 1;
        else begin
          ch = (int'(bus_addr) / 64) % 256;
          b  = int'(bus_wdata) & 255;
          if (ch == 253) begin exp_q.push_back(8'h0D); exp_hold = 1; end
          else if (b == 'hC0 || b == 'hC3) ;
          else if (b == 0) begin exp_q.push_back(8'h0A); exp_hold = 1; end
          else begin exp_q.push_back(byte'(b)); exp_hold = 1; end
        end
      end
      prev_hold = exp_hold;
    end else begin
      prev_hold = 0;
    end
  end

  bit prev_hold_r = 0;
  bit prev_hold = 0;
  // hold state as it stood before this edge (captured at the previous negedge)
  function automatic bit exp_hold_before();
    return prev_hold_r;
  endfunction

  always @(negedge clk) begin
    prev_hold_r = exp_hold;
    if (!rst_n) begin
      chk(char_valid_o == 1'b0, "R9", "char_valid in reset", char_valid_o, 0);
      chk(bus_err_o == 1'b0, "R9", "err in reset", bus_err_o, 0);
    end else begin
      chk(char_valid_o == exp_hold, "R8", "char_valid", char_valid_o, exp_hold);
      chk(bus_ready_o == !exp_hold, "R8", "bus_ready", bus_ready_o, !exp_hold);
      chk(bus_err_o == exp_err, "R6 R7", "bus_err", bus_err_o, exp_err);
      chk(bus_rdata_o == 32'd0, "R7", "rdata", bus_rdata_o, 0);
      if (exp_hold && exp_q.size() > 0)
        chk(char_o == exp_q[0], "R5", "char", char_o, exp_q[0]);
    end
    char_ready = sink_slow ? (cyc % 3 == 0) : 1'b1;
    cyc++;
  end

  task automatic access(bit wr, logic [1:0] sz, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
    while (!bus_ready_o) @(negedge clk);
    @(posedge clk);
    #1 bus_valid = 0;
  endtask

  function automatic logic [15:0] ch_addr(int ch, int off);
    return 16'((ch << 6) + off);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 plain text on the console channel
    access(1, 2'd0, ch_addr(239, 0), 32'h48);
    access(1, 2'd0, ch_addr(239, 3), 32'h69);
    // R4 NUL to line feed on another channel
    access(1, 2'd0, ch_addr(5, 0), 32'h00);
    // R3 markers dropped, neighbours pass (R5)
    access(1, 2'd0, ch_addr(5, 1), 32'hC0);
    access(1, 2'd0, ch_addr(7, 2), 32'hC3);
    access(1, 2'd0, ch_addr(7, 2), 32'hC1);
    access(1, 2'd0, ch_addr(0, 63), 32'hFF);
    // R2 flush with odd data and offset; R1 aliased upper bits
    access(1, 2'd0, ch_addr(253, 17), 32'h55);
    access(1, 2'd0, 16'h4000 | ch_addr(253, 0), 32'h00);
    access(1, 2'd0, 16'hC000 | ch_addr(252, 63), 32'hC0);
    access(1, 2'd0, ch_addr(254, 0), 32'h00);
    // R5 upper data bits ignored
    access(1, 2'd0, ch_addr(239, 0), 32'hABCD_EF41);
    // R6 non-byte writes, R7 reads
    access(1, 2'd1, ch_addr(239, 0), 32'h42);
    access(1, 2'd2, ch_addr(253, 0), 32'h43);
    access(1, 2'd3, ch_addr(239, 0), 32'h44);
    access(0, 2'd0, ch_addr(239, 0), 32'h45);
    access(0, 2'd2, ch_addr(253, 0), 32'h0);
    // R8 slow console with back-to-back writes
    sink_slow = 1;
    for (int i = 0; i < 12; i++)
      access(1, 2'd0, ch_addr(239, i), 32'h30 + i);
    access(1, 2'd0, ch_addr(253, 0), 32'h0);
    access(0, 2'd0, ch_addr(1, 0), 32'h0);
    access(1, 2'd0, ch_addr(3, 0), 32'hC3);
    sink_slow = 0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all chars drained", exp_q.size(), 0);
    finish_run();
  end
endmodule